// File: doc/BRIEF.md
# TRS Word Framer and Deserializer

This block takes a descrambled serial bit stream, one bit per clock, and packs it into 10-bit parallel words. A one-cycle strobe marks each completed word. Bits arrive least significant first. A sliding window follows the stream at every bit position and looks for the three-word timing preamble: one all-ones word followed by two all-zeros words. The fourth word of the sequence carries the line flags.

Framing enable selects what happens when a sequence arrives out of phase with the current word boundary. With framing enabled, the block moves the boundary straight away and emits the flag word on the new phase. With framing disabled, the boundary stays where it is and a sticky phase-error flag is raised. The flag clears when a sequence arrives in phase. The two line-marker outputs are active low: one for sequence detected and one for end of active video. Both are aligned with the output of the fourth word and are held for that word's period.

Top module: `trs_word_framer`

## Requirements
- R1: Each group of 10 received bits forms one word. The first bit received lands in word_o[0]. word_stb_o is high for exactly one clock when a word completes, and word_o holds that word until the next strobe.
- R2: Reset is asynchronous and active low. It clears word_o, word_stb_o and phase_err_o, and drives trs_n_o and eav_n_o high. After reset the first word completes on the 10th bit.
- R3: The bit pattern 0x3FF, 0x000, 0x000, read as consecutive 10-bit words LSB first, is recognised at any bit offset. When the word after it ends on the current boundary, that word is output with trs_n_o low.
- R4: On an accepted sequence, eav_n_o is low when bit 6 of the fourth word is 1 (end of active video). It is high when that bit is 0 (start of active video).
- R5: When frame_en_i is high and a sequence ends off the current boundary, the fourth word is output, with trs_n_o low, in the clock its last bit arrives. Later words complete every 10 bits from that point. The interrupted partial word is never output.
- R6: When frame_en_i is low and a sequence ends off the current boundary, the word cadence is unchanged, trs_n_o stays high and phase_err_o goes high.
- R7: phase_err_o stays high through data and further off-phase sequences. It clears only when a sequence is accepted, either in phase or by realignment.
- R8: trs_n_o and eav_n_o change only together with word_stb_o. They stay low for the one word period of the fourth word and return high with the next word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Serial bit clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ser_bit_i | input | 1 | Descrambled serial data bit, LSB of each word first |
| frame_en_i | input | 1 | 1: realign on an off-phase sequence; 0: keep phase and flag it |
| word_o | output | 10 | Last completed parallel word |
| word_stb_o | output | 1 | Word-rate strobe, high for one clock per completed word |
| trs_n_o | output | 1 | Active low: current word is the fourth word of an accepted sequence |
| eav_n_o | output | 1 | Active low: the accepted sequence marks end of active video |
| phase_err_o | output | 1 | Sticky flag: a sequence was seen off the word boundary and not followed |

## Verification
The hardest state to reach is a mismatch that persists: a sequence that lands off the boundary while framing is disabled, followed later by one that lands back on the old boundary. The bench reaches it by prefixing the stream with three loose bits. This places the preamble three bits off the word grid. The bench then pads with zero bits until its own bit count is a multiple of 10, so the next sequence lines up with the unchanged phase. Along the way it checks the cadence of the word positions, the sticky flag after the intermediate words, and the clearing of the flag on the in-phase word.

// File: rtl/trs_pkg.sv
package trs_pkg;
  typedef enum logic [1:0] {
    EVT_NONE,
    EVT_IN_PHASE,
    EVT_REALIGN,
    EVT_SLIP
  } trs_evt_e;

  function automatic logic evt_accepted(trs_evt_e e);
    return (e == EVT_IN_PHASE) || (e == EVT_REALIGN);
  endfunction
endpackage

// File: rtl/trs_shift_window.sv
module trs_shift_window #(
  parameter int WIN_W = 40
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bit_i,
  output logic [WIN_W-1:0] win_d_o
);
  logic [WIN_W-1:0] win_q;

  // newest bit enters at the top; oldest sits at bit 0
  assign win_d_o = {bit_i, win_q[WIN_W-1:1]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) win_q <= '0;
    else         win_q <= win_d_o;
  end
endmodule

// File: rtl/trs_preamble_det.sv
module trs_preamble_det #(
  parameter int WORD_W = 10,
  parameter int WORDS  = 4,
  localparam int PRE_W = WORD_W * (WORDS - 1)
) (
  input  logic [PRE_W-1:0] pre_i,
  output logic             hit_o
);
  logic [WORDS-2:0] word_ok;

  for (genvar g = 0; g < WORDS - 1; g++) begin : g_word
    if (g == 0) begin : g_ones
      assign word_ok[g] = &pre_i[g*WORD_W +: WORD_W];
    end else begin : g_zeros
      assign word_ok[g] = ~|pre_i[g*WORD_W +: WORD_W];
    end
  end

  assign hit_o = &word_ok;
endmodule

// File: rtl/trs_phase_ctrl.sv
module trs_phase_ctrl
  import trs_pkg::*;
#(
  parameter int WORD_W = 10
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     hit_i,
  input  logic     frame_en_i,
  output logic     word_done_o,
  output trs_evt_e evt_o,
  output logic     phase_err_o
);
  localparam int CNT_W = $clog2(WORD_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

  logic [CNT_W-1:0] cnt_q, cnt_inc, cnt_d;
  logic             on_grid;

  always_comb begin
    cnt_inc = (cnt_q == LAST) ? '0 : cnt_q + CNT_W'(1);
    on_grid = (cnt_inc == '0);
    evt_o   = EVT_NONE;
    if (hit_i) begin
      if (on_grid)         evt_o = EVT_IN_PHASE;
      else if (frame_en_i) evt_o = EVT_REALIGN;
      else                 evt_o = EVT_SLIP;
    end
    // realignment restarts the count so this bit closes a word
    cnt_d       = (evt_o == EVT_REALIGN) ? '0 : cnt_inc;
    word_done_o = (cnt_d == '0);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q       <= '0;
      phase_err_o <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      unique case (evt_o)
        EVT_SLIP:                  phase_err_o <= 1'b1;
        EVT_IN_PHASE, EVT_REALIGN: phase_err_o <= 1'b0;
        default:                   phase_err_o <= phase_err_o;
      endcase
    end
  end
endmodule

// File: rtl/trs_word_framer.sv
module trs_word_framer
  import trs_pkg::*;
#(
  parameter int WORD_W = 10,
  parameter int WORDS  = 4,
  parameter int H_BIT  = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ser_bit_i,
  input  logic              frame_en_i,
  output logic [WORD_W-1:0] word_o,
  output logic              word_stb_o,
  output logic              trs_n_o,
  output logic              eav_n_o,
  output logic              phase_err_o
);
  localparam int WIN_W = WORD_W * WORDS;
  localparam int PRE_W = WORD_W * (WORDS - 1);

  logic [WIN_W-1:0] win_d;
  logic             hit;
  logic             word_done;
  trs_evt_e         evt;
  logic             acc;

  trs_shift_window #(.WIN_W(WIN_W)) i_window (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .bit_i   (ser_bit_i),
    .win_d_o (win_d)
  );

  trs_preamble_det #(.WORD_W(WORD_W), .WORDS(WORDS)) i_det (
    .pre_i (win_d[PRE_W-1:0]),
    .hit_o (hit)
  );

  trs_phase_ctrl #(.WORD_W(WORD_W)) i_phase (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .hit_i       (hit),
    .frame_en_i  (frame_en_i),
    .word_done_o (word_done),
    .evt_o       (evt),
    .phase_err_o (phase_err_o)
  );

  assign acc = evt_accepted(evt);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_o     <= '0;
      word_stb_o <= 1'b0;
      trs_n_o    <= 1'b1;
      eav_n_o    <= 1'b1;
    end else begin
      word_stb_o <= word_done;
      if (word_done) begin
        word_o  <= win_d[WIN_W-1 -: WORD_W];
        trs_n_o <= ~acc;
        eav_n_o <= ~(acc & win_d[PRE_W + H_BIT]);
      end
    end
  end
endmodule

// File: rtl/trs_framer_chk.sv
module trs_framer_chk #(
  parameter int WORD_W = 10
) (
  input logic clk_i,
  input logic rst_ni,
  input logic frame_en_i,
  input logic word_h_i,
  input logic word_stb_o,
  input logic trs_n_o,
  input logic eav_n_o,
  input logic phase_err_o
);
  logic [7:0] gap_q;
  logic       first_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gap_q   <= '0;
      first_q <= 1'b1;
    end else if (word_stb_o) begin
      gap_q   <= '0;
      first_q <= 1'b0;
    end else if (gap_q != 8'hFF) begin
      gap_q <= gap_q + 8'd1;
    end
  end

  // R1
  word_cadence_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (word_stb_o && trs_n_o && !first_q) |-> (gap_q == 8'(WORD_W - 1)));

  // R8
  flag_on_stb_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(trs_n_o) || !$stable(eav_n_o)) |-> word_stb_o);

  // R4
  eav_h_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !eav_n_o |-> (!trs_n_o && word_h_i));

  // R4
  sav_h_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!trs_n_o && eav_n_o) |-> !word_h_i);

  // R6
  slip_only_unframed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(phase_err_o) |-> !$past(frame_en_i));

  // R7
  err_clear_on_accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(phase_err_o) |-> (word_stb_o && !trs_n_o));
endmodule

bind trs_word_framer trs_framer_chk #(.WORD_W(WORD_W)) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .frame_en_i  (frame_en_i),
  .word_h_i    (word_o[H_BIT]),
  .word_stb_o  (word_stb_o),
  .trs_n_o     (trs_n_o),
  .eav_n_o     (eav_n_o),
  .phase_err_o (phase_err_o)
);

// File: tb/test_trs_word_framer.sv
module test_trs_word_framer;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       ser_bit_i = 1'b0;
  logic       frame_en_i = 1'b1;
  logic [9:0] word_o;
  logic       word_stb_o, trs_n_o, eav_n_o, phase_err_o;

  trs_word_framer i_trs_word_framer (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ser_bit_i   (ser_bit_i),
    .frame_en_i  (frame_en_i),
    .word_o      (word_o),
    .word_stb_o  (word_stb_o),
    .trs_n_o     (trs_n_o),
    .eav_n_o     (eav_n_o),
    .phase_err_o (phase_err_o)
  );

  always #5 clk_i = ~clk_i;

  int n_chk = 0, n_fail = 0, nbits = 0, rec_n = 0, cyc = 0;
  logic [9:0] rec_word [64];
  logic       rec_trs  [64];
  logic       rec_eav  [64];
  logic       rec_perr [64];
  int         rec_pos  [64];

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 150000) begin
      n_fail++;
      $display("FAIL watchdog: got %0d cycles expected fewer than 150000", cyc);
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic push_bit(logic b);
    ser_bit_i = b;
    @(negedge clk_i);
    nbits++;
    if (word_stb_o && rec_n < 64) begin
      rec_word[rec_n] = word_o;
      rec_trs[rec_n]  = trs_n_o;
      rec_eav[rec_n]  = eav_n_o;
      rec_perr[rec_n] = phase_err_o;
      rec_pos[rec_n]  = nbits;
      rec_n++;
    end
  endtask

  task automatic push_word(logic [9:0] w);
    for (int i = 0; i < 10; i++) push_bit(w[i]);
  endtask

  task automatic push_trs(logic [9:0] xyz);
    push_word(10'h3FF);
    push_word(10'h000);
    push_word(10'h000);
    push_word(xyz);
  endtask

  task automatic do_reset();
    ser_bit_i = 1'b0;
    rst_ni = 1'b0;
    @(negedge clk_i);
    @(negedge clk_i);
    rst_ni = 1'b1;
    nbits = 0;
    rec_n = 0;
  endtask

  task automatic t_plain_words();
    do_reset();
    frame_en_i = 1'b1;
    push_word(10'h2A5);
    push_word(10'h13C);
    push_word(10'h3FE);
    chk("R1", "word count", rec_n, 3);
    chk("R2", "first word position", rec_pos[0], 10);
    chk("R1", "second word position", rec_pos[1], 20);
    chk("R1", "word 0", rec_word[0], 10'h2A5);
    chk("R1", "word 1", rec_word[1], 10'h13C);
    chk("R1", "word 2", rec_word[2], 10'h3FE);
    chk("R3", "trs_n on data", rec_trs[2], 1);
    push_bit(1'b0);
    chk("R1", "strobe single cycle", word_stb_o, 0);
    chk("R1", "word held", word_o, 10'h3FE);
  endtask

  task automatic t_eav_in_phase();
    do_reset();
    frame_en_i = 1'b1;
    push_word(10'h155);
    push_trs(10'h274);
    chk("R3", "trs word count", rec_n, 5);
    chk("R3", "preamble word not flagged", rec_trs[1], 1);
    chk("R3", "fourth word value", rec_word[4], 10'h274);
    chk("R3", "fourth word trs_n", rec_trs[4], 0);
    chk("R4", "eav_n on H=1", rec_eav[4], 0);
    for (int i = 0; i < 5; i++) push_bit(1'b0);
    chk("R8", "trs_n held mid word", trs_n_o, 0);
    chk("R8", "eav_n held mid word", eav_n_o, 0);
    for (int i = 0; i < 5; i++) push_bit(1'b1);
    chk("R8", "trs_n released next word", rec_trs[5], 1);
    chk("R8", "eav_n released next word", rec_eav[5], 1);
    chk("R1", "next word value", rec_word[5], 10'h3E0);
  endtask

  task automatic t_sav();
    do_reset();
    frame_en_i = 1'b1;
    push_trs(10'h200);
    push_word(10'h3C3);
    chk("R4", "sav word", rec_word[3], 10'h200);
    chk("R4", "sav trs_n", rec_trs[3], 0);
    chk("R4", "sav eav_n high", rec_eav[3], 1);
    chk("R8", "following trs_n", rec_trs[4], 1);
  endtask

  task automatic t_realign();
    do_reset();
    frame_en_i = 1'b1;
    push_bit(1'b1); push_bit(1'b0); push_bit(1'b1);
    push_trs(10'h274);
    push_word(10'h123);
    push_word(10'h0F0);
    chk("R5", "record count", rec_n, 7);
    chk("R5", "realigned word position", rec_pos[4], 43);
    chk("R5", "realigned word", rec_word[4], 10'h274);
    chk("R5", "realigned trs_n", rec_trs[4], 0);
    chk("R5", "realigned eav_n", rec_eav[4], 0);
    chk("R5", "next position", rec_pos[5], 53);
    chk("R5", "next word", rec_word[5], 10'h123);
    chk("R5", "last word", rec_word[6], 10'h0F0);
    chk("R5", "no phase error", phase_err_o, 0);
  endtask

  task automatic t_slip_and_recover();
    do_reset();
    frame_en_i = 1'b0;
    push_bit(1'b1); push_bit(1'b0); push_bit(1'b1);
    push_trs(10'h274);
    push_word(10'h123);
    push_word(10'h0F0);
    chk("R6", "record count", rec_n, 6);
    chk("R6", "cadence kept", rec_pos[4], 50);
    chk("R6", "no trs flag", rec_trs[4], 1);
    chk("R6", "err before slip", rec_perr[3], 0);
    chk("R6", "err after slip", rec_perr[4], 1);
    for (int i = 0; i < 7; i++) push_bit(1'b0);
    chk("R7", "err sticky over data", phase_err_o, 1);
    push_trs(10'h200);
    chk("R7", "err sticky before in-phase", rec_perr[9], 1);
    chk("R3", "in-phase position", rec_pos[10], 110);
    chk("R3", "in-phase trs_n", rec_trs[10], 0);
    chk("R4", "in-phase eav_n", rec_eav[10], 1);
    chk("R7", "err cleared", rec_perr[10], 0);
    frame_en_i = 1'b1;
  endtask

  task automatic t_reset();
    do_reset();
    frame_en_i = 1'b0;
    push_bit(1'b1);
    push_trs(10'h274);
    push_bit(1'b0);
    chk("R6", "err set before reset", phase_err_o, 1);
    rst_ni = 1'b0;
    #2;
    chk("R2", "reset word", word_o, 0);
    chk("R2", "reset strobe", word_stb_o, 0);
    chk("R2", "reset trs_n", trs_n_o, 1);
    chk("R2", "reset eav_n", eav_n_o, 1);
    chk("R2", "reset phase_err", phase_err_o, 0);
    frame_en_i = 1'b1;
  endtask

  initial begin
    t_plain_words();
    t_eav_in_phase();
    t_sav();
    t_realign();
    t_slip_and_recover();
    t_reset();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule